// File: doc/BRIEF.md
# Syncpoint Counter Bank with Threshold Interrupts

This block keeps a bank of 32-bit syncpoint counters, one for each syncpoint ID. Clients send commands on one valid/ready command port. A command can increment a counter, register a threshold on a counter, or cancel a threshold registered earlier. Each counter has a small list of pending thresholds, and the list never holds the same value twice. After an increment, every pending threshold that the new count has reached raises an interrupt and is then removed from the list. The interrupts leave one at a time through a valid/ready interrupt port.

A separate combinational fence-wait port reports whether a counter has reached a requested value. A shutdown input releases every wait at once. A plain read port returns any counter's current value.

Back-pressure rules:
- The command port takes a command only while `cmd_ready` is high. It handles commands one at a time, in arrival order.
- After an increment, `cmd_ready` stays low until all interrupts caused by that increment have been handed off.
- The interrupt port holds `irq_valid`, `irq_id` and `irq_value` steady while `irq_ready` is low. An interrupt is handed off on a clock edge where both `irq_valid` and `irq_ready` are high.

Top module: `sp_sync_bank`

## Requirements
- R1: An increment command (op 2'b00) adds exactly one to the addressed counter and leaves every other counter unchanged.
- R2: Once an increment completes, each pending threshold on that ID that is less than or equal to the new count produces one interrupt, carrying the ID and the threshold value. The threshold is then removed from the list.
- R3: A pending threshold that is still above the count stays in the list and fires on a later increment that reaches it.
- R4: A register command (op 2'b01) stores its value in the lowest-numbered free slot of the ID. If that value is already pending on the same ID, the command has no effect, so each threshold fires only once.
- R5: If all 4 slots of the ID are occupied and the value is new, `reg_overflow` pulses in the cycle after acceptance and the value is dropped.
- R6: A cancel command (op 2'b10) removes a matching pending threshold. In the cycle after acceptance, `cancel_done` pulses, and `cancel_hit` is high if a match was removed and low otherwise. Op 2'b11 is accepted and does nothing.
- R7: When one increment reaches several thresholds, their interrupts leave one per handshake in ascending slot order. While `irq_ready` is low, the interrupt outputs hold steady and `cmd_ready` stays low.
- R8: For an in-range `wait_id`, `wait_ready` is high exactly when the counter is greater than or equal to `wait_value`.
- R9: While `shutdown` is high, `wait_ready` is high regardless of counter values.
- R10: A `wait_id` at or above the syncpoint count (including all-ones) raises `wait_err` and makes `wait_ready` high at once.
- R11: After reset, all counters are zero, no thresholds are pending, `cmd_ready` is high and `irq_valid` is low.
- R12: `rd_value` returns the current count of the counter selected by `rd_id`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 00 increment, 01 register, 10 cancel, 11 no-op |
| cmd_id | input | 4 | Target syncpoint |
| cmd_value | input | 32 | Threshold for register/cancel |
| reg_overflow | output | 1 | Pulse: register dropped, list full |
| cancel_done | output | 1 | Pulse: cancel handled |
| cancel_hit | output | 1 | With cancel_done: threshold found and removed |
| irq_valid | output | 1 | Interrupt pending |
| irq_ready | input | 1 | Consumer takes the interrupt |
| irq_id | output | 4 | Syncpoint of the interrupt |
| irq_value | output | 32 | Threshold that fired |
| rd_id | input | 4 | Read-port syncpoint select |
| rd_value | output | 32 | Current count of rd_id |
| wait_id | input | 5 | Fence-wait syncpoint (out-of-range IDs are errors) |
| wait_value | input | 32 | Fence-wait target |
| shutdown | input | 1 | Release all waits |
| wait_ready | output | 1 | Fence wait satisfied |
| wait_err | output | 1 | Fence-wait ID out of range |

## Verification
The assertions assume that counters never wrap past 2^32-1. Under that assumption, a wait that is satisfied stays satisfied while its ID and target are unchanged. The stimulus uses counts below 10, so wrap-around is never reached. The assertions also assume that a producer of commands changes nothing while `cmd_ready` is low, and that the consumer may stall `irq_ready` for any number of cycles. The stimulus drives inputs only on falling edges, holds a command for exactly the acceptance cycle, and stalls the interrupt port only in a dedicated back-pressure test.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    OP_INC    = 2'b00,
    OP_REG    = 2'b01,
    OP_CANCEL = 2'b10,
    OP_NONE   = 2'b11
  } sp_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FIRE = 1'b1
  } sp_state_e;
endpackage

// File: rtl/sp_counter_bank.sv
module sp_counter_bank #(
  parameter int NUM_SP = 16,
  parameter int CW     = 32,
  localparam int IDW   = $clog2(NUM_SP)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inc_en,
  input  logic [IDW-1:0] inc_id,
  input  logic [IDW-1:0] rd_a_id,
  output logic [CW-1:0]  rd_a_val,
  input  logic [IDW-1:0] rd_b_id,
  output logic [CW-1:0]  rd_b_val,
  input  logic [IDW-1:0] rd_c_id,
  output logic [CW-1:0]  rd_c_val
);
  logic [CW-1:0] cnt_q [NUM_SP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SP; i++) cnt_q[i] <= '0;
    end else if (inc_en) begin
      cnt_q[inc_id] <= cnt_q[inc_id] + 1'b1;
    end
  end

  assign rd_a_val = cnt_q[rd_a_id];
  assign rd_b_val = cnt_q[rd_b_id];
  assign rd_c_val = cnt_q[rd_c_id];

  // R1: the addressed counter advances by exactly one
  p_inc_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |=> cnt_q[$past(inc_id)] == $past(cnt_q[inc_id]) + 1'b1);

  // R1: counters other than the addressed one hold their value
  generate
    for (genvar g = 0; g < NUM_SP; g++) begin : g_hold
      p_other_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_en && inc_id == IDW'(g)) |=> $stable(cnt_q[g]));
    end
  endgenerate
endmodule

// File: rtl/sp_threshold_table.sv
module sp_threshold_table #(
  parameter int NUM_SP = 16,
  parameter int SLOTS  = 4,
  parameter int CW     = 32,
  localparam int IDW   = $clog2(NUM_SP),
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDW-1:0]   op_id,
  input  logic [CW-1:0]    op_value,
  input  logic             reg_en,
  input  logic             cancel_en,
  output logic             match_o,
  output logic             full_o,
  input  logic [IDW-1:0]   scan_id,
  input  logic [CW-1:0]    scan_cnt,
  output logic [SLOTS-1:0] due_o,
  output logic [CW-1:0]    due_val_o,
  output logic [SW-1:0]    due_slot_o,
  input  logic             retire_en
);
  logic [CW-1:0]    thr_q [NUM_SP][SLOTS];
  logic [SLOTS-1:0] vld_q [NUM_SP];

  logic [SLOTS-1:0] match_vec;
  logic [SW-1:0]    free_slot;
  logic             store_en;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      match_vec[s] = vld_q[op_id][s] && (thr_q[op_id][s] == op_value);
      due_o[s]     = vld_q[scan_id][s] && (thr_q[scan_id][s] <= scan_cnt);
    end
  end

  always_comb begin
    free_slot = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!vld_q[op_id][s]) free_slot = SW'(s);
    end
  end

  always_comb begin
    due_slot_o = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (due_o[s]) due_slot_o = SW'(s);
    end
  end

  assign match_o   = |match_vec;
  assign full_o    = &vld_q[op_id];
  assign due_val_o = thr_q[scan_id][due_slot_o];
  assign store_en  = reg_en && !match_o && !full_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SP; i++) vld_q[i] <= '0;
    end else begin
      if (store_en) vld_q[op_id][free_slot] <= 1'b1;
      if (cancel_en) vld_q[op_id] <= vld_q[op_id] & ~match_vec;
      if (retire_en) vld_q[scan_id][due_slot_o] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (store_en) thr_q[op_id][free_slot] <= op_value;
  end

  // R2: a retired slot is empty on the next cycle
  p_retire_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    retire_en |=> !vld_q[$past(scan_id)][$past(due_slot_o)]);

  // R4: an accepted new threshold is pending afterwards
  p_reg_stored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !full_o) |=> (op_id == $past(op_id) && op_value == $past(op_value)) -> match_o);

  // R5: a register into a full list leaves the list untouched
  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && full_o && !match_o) |=> vld_q[$past(op_id)] == $past(vld_q[op_id]));

  // R4: no two valid slots of one syncpoint hold the same value
  generate
    for (genvar p = 0; p < NUM_SP; p++) begin : g_sp
      for (genvar a = 0; a < SLOTS; a++) begin : g_a
        for (genvar b = a + 1; b < SLOTS; b++) begin : g_b
          p_no_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(vld_q[p][a] && vld_q[p][b] && thr_q[p][a] == thr_q[p][b]));
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sp_fence_wait.sv
module sp_fence_wait #(
  parameter int NUM_SP = 16,
  parameter int CW     = 32,
  localparam int IDW   = $clog2(NUM_SP)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IDW:0]   wait_id,
  input  logic [CW-1:0]  wait_value,
  input  logic [CW-1:0]  cur_cnt,
  input  logic           shutdown,
  output logic [IDW-1:0] lookup_id,
  output logic           wait_ready,
  output logic           wait_err
);
  logic in_range;

  assign in_range   = (wait_id < (IDW+1)'(NUM_SP));
  assign lookup_id  = wait_id[IDW-1:0];
  assign wait_err   = !in_range;
  assign wait_ready = shutdown || !in_range || (cur_cnt >= wait_value);

  // R8: counters only rise, so a satisfied wait stays satisfied while its request is held
  p_wait_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_ready && !shutdown) |=>
      (!$stable(wait_id) || !$stable(wait_value) || wait_ready));
endmodule

// File: rtl/sp_sync_bank.sv
module sp_sync_bank
  import sp_pkg::*;
#(
  parameter int NUM_SP = 16,
  parameter int SLOTS  = 4,
  parameter int CW     = 32,
  localparam int IDW   = $clog2(NUM_SP),
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [1:0]     cmd_op,
  input  logic [IDW-1:0] cmd_id,
  input  logic [CW-1:0]  cmd_value,
  output logic           reg_overflow,
  output logic           cancel_done,
  output logic           cancel_hit,
  output logic           irq_valid,
  input  logic           irq_ready,
  output logic [IDW-1:0] irq_id,
  output logic [CW-1:0]  irq_value,
  input  logic [IDW-1:0] rd_id,
  output logic [CW-1:0]  rd_value,
  input  logic [IDW:0]   wait_id,
  input  logic [CW-1:0]  wait_value,
  input  logic           shutdown,
  output logic           wait_ready,
  output logic           wait_err
);
  sp_state_e        state_q;
  logic [IDW-1:0]   fire_id_q;
  logic             accept;
  sp_op_e           op;
  logic             match, full;
  logic [SLOTS-1:0] due;
  logic [CW-1:0]    due_val;
  logic [SW-1:0]    due_slot;
  logic [CW-1:0]    fire_cnt, wait_cnt;
  logic [IDW-1:0]   wait_lookup;
  logic             retire;

  assign op        = sp_op_e'(cmd_op);
  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign irq_valid = (state_q == ST_FIRE) && (|due);
  assign irq_id    = fire_id_q;
  assign irq_value = due_val;
  assign retire    = irq_valid && irq_ready;

  sp_counter_bank #(.NUM_SP(NUM_SP), .CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_en   (accept && op == OP_INC),
    .inc_id   (cmd_id),
    .rd_a_id  (rd_id),
    .rd_a_val (rd_value),
    .rd_b_id  (fire_id_q),
    .rd_b_val (fire_cnt),
    .rd_c_id  (wait_lookup),
    .rd_c_val (wait_cnt)
  );

  sp_threshold_table #(.NUM_SP(NUM_SP), .SLOTS(SLOTS), .CW(CW)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_id      (cmd_id),
    .op_value   (cmd_value),
    .reg_en     (accept && op == OP_REG),
    .cancel_en  (accept && op == OP_CANCEL),
    .match_o    (match),
    .full_o     (full),
    .scan_id    (fire_id_q),
    .scan_cnt   (fire_cnt),
    .due_o      (due),
    .due_val_o  (due_val),
    .due_slot_o (due_slot),
    .retire_en  (retire)
  );

  sp_fence_wait #(.NUM_SP(NUM_SP), .CW(CW)) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_id    (wait_id),
    .wait_value (wait_value),
    .cur_cnt    (wait_cnt),
    .shutdown   (shutdown),
    .lookup_id  (wait_lookup),
    .wait_ready (wait_ready),
    .wait_err   (wait_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      fire_id_q    <= '0;
      reg_overflow <= 1'b0;
      cancel_done  <= 1'b0;
      cancel_hit   <= 1'b0;
    end else begin
      reg_overflow <= accept && op == OP_REG && !match && full;
      cancel_done  <= accept && op == OP_CANCEL;
      cancel_hit   <= accept && op == OP_CANCEL && match;
      case (state_q)
        ST_IDLE: if (accept && op == OP_INC) begin
          state_q   <= ST_FIRE;
          fire_id_q <= cmd_id;
        end
        ST_FIRE: if (!(|due)) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: a stalled interrupt holds its payload
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> irq_valid && $stable(irq_id) && $stable(irq_value));

  // R7: successive interrupts of one burst come from rising slot numbers
  p_slot_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && state_q == ST_FIRE) |=> !irq_valid || due_slot > $past(due_slot));

  // R2: every interrupt carries a threshold already reached by its counter
  p_irq_reached_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_value <= fire_cnt);

  // R6: a hit is only reported together with a completed cancel
  p_hit_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_hit |-> cancel_done);
endmodule

// File: tb/tb_sp_sync_bank.sv
module tb_sp_sync_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  id;
    logic [31:0] val;
    logic [31:0] cnt;
    logic [3:0]  n;
    logic [31:0] sum;
    logic [31:0] first;
    logic        flag;
  } vec_t;

  // op 0 inc, 1 register, 2 cancel; flag = overflow (register) or hit (cancel)
  localparam vec_t VECS [NV] = '{
    '{2'd1, 4'd3, 32'd2, 32'd0, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd1, 4'd3, 32'd2, 32'd0, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd1, 4'd3, 32'd1, 32'd0, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd1, 4'd3, 32'd5, 32'd0, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd1, 4'd3, 32'd9, 32'd0, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd1, 4'd3, 32'd7, 32'd0, 4'd0, 32'd0, 32'd0, 1'b1},
    '{2'd0, 4'd3, 32'd0, 32'd1, 4'd1, 32'd1, 32'd1, 1'b0},
    '{2'd0, 4'd3, 32'd0, 32'd2, 4'd1, 32'd2, 32'd2, 1'b0},
    '{2'd2, 4'd3, 32'd9, 32'd2, 4'd0, 32'd0, 32'd0, 1'b1},
    '{2'd2, 4'd3, 32'd9, 32'd2, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd0, 4'd3, 32'd0, 32'd3, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd1, 4'd3, 32'd4, 32'd3, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd1, 4'd3, 32'd3, 32'd3, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd0, 4'd3, 32'd0, 32'd4, 4'd2, 32'd7, 32'd4, 1'b0},
    '{2'd0, 4'd3, 32'd0, 32'd5, 4'd1, 32'd5, 32'd5, 1'b0},
    '{2'd0, 4'd0, 32'd0, 32'd1, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd1, 4'd1, 32'd0, 32'd0, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd0, 4'd1, 32'd0, 32'd1, 4'd1, 32'd0, 32'd0, 1'b0},
    '{2'd1, 4'd3, 32'd7, 32'd5, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd0, 4'd3, 32'd0, 32'd6, 4'd0, 32'd0, 32'd0, 1'b0},
    '{2'd0, 4'd3, 32'd0, 32'd7, 4'd1, 32'd7, 32'd7, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [3:0]  cmd_id = '0;
  logic [31:0] cmd_value = '0;
  logic        reg_overflow, cancel_done, cancel_hit;
  logic        irq_valid;
  logic        irq_ready = 1'b1;
  logic [3:0]  irq_id;
  logic [31:0] irq_value;
  logic [3:0]  rd_id = '0;
  logic [31:0] rd_value;
  logic [4:0]  wait_id = '0;
  logic [31:0] wait_value = '0;
  logic        shutdown = 1'b0;
  logic        wait_ready, wait_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_sync_bank dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_id(cmd_id), .cmd_value(cmd_value),
    .reg_overflow(reg_overflow), .cancel_done(cancel_done), .cancel_hit(cancel_hit),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_id(irq_id), .irq_value(irq_value),
    .rd_id(rd_id), .rd_value(rd_value),
    .wait_id(wait_id), .wait_value(wait_value), .shutdown(shutdown),
    .wait_ready(wait_ready), .wait_err(wait_err)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int n = 0;
    longint sum = 0;
    longint first = 0;
    bit flag;
    @(negedge clk);
    cmd_op = v.op; cmd_id = v.id; cmd_value = v.val; rd_id = v.id;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    flag = (v.op == 2'd1) ? reg_overflow : (v.op == 2'd2) ? (cancel_done && cancel_hit) : 1'b0;
    if (v.op == 2'd2) check(cancel_done == 1'b1, "R6 cancel_done", cancel_done, 1);
    while (!cmd_ready && !done) begin
      if (irq_valid) begin
        n++;
        if (n == 1) first = irq_value;
        sum += irq_value;
        check(irq_id == v.id, "R2 irq_id", irq_id, v.id);
      end
      @(posedge clk);
      @(negedge clk);
    end
    $display("vector %0d", idx);
    check(rd_value == v.cnt, "R1/R12 count", rd_value, v.cnt);
    check(n == v.n, "R2 R3 irq count", n, v.n);
    check(sum == v.sum, "R2 R4 irq sum", sum, v.sum);
    if (v.n > 1) check(first == v.first, "R7 slot order", first, v.first);
    check(flag == v.flag, (v.op == 2'd1) ? "R5 overflow" : "R6 hit", flag, v.flag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", 1, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(cmd_ready == 1'b1, "R11 cmd_ready", cmd_ready, 1);
    check(irq_valid == 1'b0, "R11 irq_valid", irq_valid, 0);
    rd_id = 4'd0;  #1 check(rd_value == 0, "R11 count0", rd_value, 0);
    rd_id = 4'd15; #1 check(rd_value == 0, "R11 count15", rd_value, 0);
    wait_id = 5'd0; wait_value = 32'd0; #1
    check(wait_ready == 1'b1, "R8 zero target", wait_ready, 1);
    wait_value = 32'd1; #1
    check(wait_ready == 1'b0, "R8 unreached", wait_ready, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // op 11 does nothing
    @(negedge clk);
    cmd_op = 2'd3; cmd_id = 4'd3; rd_id = 4'd3; cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk); cmd_valid = 1'b0;
    check(rd_value == 7 && !cancel_done && !reg_overflow && cmd_ready, "R6 noop op", rd_value, 7);

    // fence wait on syncpoint 3 (count 7)
    wait_id = 5'd3; wait_value = 32'd7; #1
    check(wait_ready == 1'b1 && !wait_err, "R8 equal", wait_ready, 1);
    wait_value = 32'd8; #1
    check(wait_ready == 1'b0, "R8 above", wait_ready, 0);
    shutdown = 1'b1; #1
    check(wait_ready == 1'b1, "R9 shutdown", wait_ready, 1);
    shutdown = 1'b0; #1
    check(wait_ready == 1'b0, "R9 release ends", wait_ready, 0);
    wait_id = 5'h1F; #1
    check(wait_ready && wait_err, "R10 all-ones id", {wait_ready, wait_err}, 3);
    wait_id = 5'd16; #1
    check(wait_ready && wait_err, "R10 out of range id", {wait_ready, wait_err}, 3);

    // R7 back-pressure: two thresholds on id 2 fire on one increment
    run_vec('{2'd1, 4'd2, 32'd0, 32'd0, 4'd0, 32'd0, 32'd0, 1'b0}, 100);
    run_vec('{2'd1, 4'd2, 32'd1, 32'd0, 4'd0, 32'd0, 32'd0, 1'b0}, 101);
    irq_ready = 1'b0;
    @(negedge clk);
    cmd_op = 2'd0; cmd_id = 4'd2; rd_id = 4'd2; cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk); cmd_valid = 1'b0;
    check(irq_valid && irq_value == 0 && irq_id == 2, "R7 first irq", irq_value, 0);
    repeat (3) @(negedge clk);
    check(irq_valid && irq_value == 0, "R7 held while stalled", irq_value, 0);
    check(cmd_ready == 1'b0, "R7 busy while stalled", cmd_ready, 0);
    irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
    check(irq_valid && irq_value == 1, "R7 second irq", irq_value, 1);
    @(negedge clk);
    irq_ready = 1'b1;
    @(negedge clk);
    check(!irq_valid, "R7 burst drained", irq_valid, 0);
    @(negedge clk);
    check(cmd_ready && rd_value == 1, "R1 id2 count", rd_value, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule